// File: doc/BRIEF.md
# Four/Five-Step Frame Sequencer

This block produces the slow timing beats for a sound generator. It counts processor cycles, qualified by a cycle enable, and at fixed intervals emits a one-cycle quarter-frame strobe and a one-cycle half-frame strobe. The envelope, linear-counter, length and sweep units downstream consume those strobes. In one of its two sequences it also raises a frame interrupt flag once per sequence. A control write chooses the sequence and can mask the interrupt. A one-cycle clear input, driven by the status-read path, drops the flag.

The sequence is a named state machine with states `ST_S0`, `ST_S1`, `ST_S2`, `ST_S3` and `ST_S4`. In four-step mode the path is ST_S0 → ST_S1 → ST_S2 → ST_S3 → ST_S0. In five-step mode the path is ST_S0 → ST_S1 → ST_S2 → ST_S3 → ST_S4 → ST_S0. A control write sends the machine to ST_S0 from any state. A step transition happens on the enabled cycle in which the down-counting interval divider expires. On that cycle the divider reloads with `PERIOD`. A control write instead loads `PERIOD + WR_DELAY`, which gives a longer first step. Reset returns the machine to ST_S0 with the divider at `PERIOD`.

Top module: `frame_sequencer`

## Requirements
- R1: While reset is asserted, and after its release, both strobes and the interrupt flag are low. After release the machine is in ST_S0 with the divider at `PERIOD`, so the first step fires on the `PERIOD+1`-th enabled cycle.
- R2: The divider moves only on cycles with `cyc_en` high. One step fires every `PERIOD+1` enabled cycles. With `cyc_en` low, nothing advances.
- R3: In four-step mode every step gives a quarter strobe. Steps ST_S1 and ST_S3 also give a half strobe. After ST_S3 the machine wraps to ST_S0.
- R4: In four-step mode, step ST_S3 sets the interrupt flag, unless the inhibit is set. The flag is visible in the same cycle as that step's strobes.
- R5: In five-step mode every step except ST_S3 gives a quarter strobe. The half strobe comes on ST_S1 and ST_S4. The machine wraps after ST_S4, and the flag is never set.
- R6: A control write (`ctl_wr`) decodes two bits of `ctl_data`: bit 7 = 1 selects five-step mode, and bit 6 = 1 sets the inhibit. The write returns the machine to ST_S0 and loads the divider with `PERIOD+WR_DELAY`. A write with bit 7 = 0 gives no strobe. The write acts whatever the value of `cyc_en`, and it overrides a divider tick in the same cycle.
- R7: A control write with bit 7 = 1 raises both strobes in the cycle after the write.
- R8: A control write with bit 6 = 1 clears the interrupt flag in the cycle after the write.
- R9: `irq_clr` clears the flag in the next cycle. If a step sets the flag in the same cycle as the clear, the set wins.
- R10: Every strobe is one cycle wide. A half strobe never appears without a quarter strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Processor-cycle enable for the divider |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 8 | Control write data (bit 7 five-step, bit 6 inhibit) |
| irq_clr | input | 1 | One-cycle clear of the interrupt flag |
| qtr_stb | output | 1 | Quarter-frame strobe |
| half_stb | output | 1 | Half-frame strobe |
| irq_flag | output | 1 | Frame interrupt flag |

## Verification
The bench builds the block with `PERIOD` = 12 and `WR_DELAY` = 8. A whole four-step sequence then takes 52 enabled cycles and a five-step one takes 65. This puts several wraps of both modes, the longer first step after a write, and interrupts from repeated ST_S3 steps within a few hundred cycles. These short values also let a flag set coincide with a held clear, let the cycle enable gate the divider, and let writes land with and without the enable.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef enum logic [2:0] {
        ST_S0 = 3'd0,
        ST_S1 = 3'd1,
        ST_S2 = 3'd2,
        ST_S3 = 3'd3,
        ST_S4 = 3'd4
    } fs_step_e;

    typedef enum logic {
        MODE_FOUR = 1'b0,
        MODE_FIVE = 1'b1
    } fs_mode_e;

    typedef struct packed {
        logic qtr;
        logic half;
        logic irq_set;
    } fs_action_t;

    localparam int CTL_FIVE_BIT = 7;
    localparam int CTL_INH_BIT  = 6;

endpackage

// File: rtl/fs_divider.sv
module fs_divider #(
    parameter int PERIOD   = 7456,
    parameter int WR_DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic load_long,
    output logic expire
);
    localparam int CW = $clog2(PERIOD + WR_DELAY + 1);
    localparam logic [CW-1:0] RELOAD_STD  = CW'(PERIOD);
    localparam logic [CW-1:0] RELOAD_LONG = CW'(PERIOD + WR_DELAY);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= RELOAD_STD;
        end else if (load_long) begin
            count_q <= RELOAD_LONG;
        end else if (cyc_en) begin
            if (count_q == '0) begin
                count_q <= RELOAD_STD;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    assign expire = cyc_en && !load_long && (count_q == '0);

endmodule

// File: rtl/fs_step_fsm.sv
module fs_step_fsm
    import fs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       ctl_wr,
    input  logic       five_sel,
    output fs_mode_e   mode,
    output fs_action_t action
);
    fs_step_e state_q, state_d;
    fs_mode_e mode_q;

    // State register: mode and step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_S0;
            mode_q  <= MODE_FOUR;
        end else if (ctl_wr) begin
            state_q <= ST_S0;
            mode_q  <= five_sel ? MODE_FIVE : MODE_FOUR;
        end else if (tick) begin
            state_q <= state_d;
        end
    end

    // Next step
    always_comb begin
        state_d = ST_S0;
        unique case (state_q)
            ST_S0:   state_d = ST_S1;
            ST_S1:   state_d = ST_S2;
            ST_S2:   state_d = ST_S3;
            ST_S3:   state_d = (mode_q == MODE_FIVE) ? ST_S4 : ST_S0;
            ST_S4:   state_d = ST_S0;
            default: state_d = ST_S0;
        endcase
    end

    // Action decode for the current step
    always_comb begin
        action = '0;
        unique case (state_q)
            ST_S0: begin
                action.qtr = 1'b1;
            end
            ST_S1: begin
                action.qtr  = 1'b1;
                action.half = 1'b1;
            end
            ST_S2: begin
                action.qtr = 1'b1;
            end
            ST_S3: begin
                action.qtr     = (mode_q == MODE_FOUR);
                action.half    = (mode_q == MODE_FOUR);
                action.irq_set = (mode_q == MODE_FOUR);
            end
            ST_S4: begin
                action.qtr  = 1'b1;
                action.half = 1'b1;
            end
            default: action = '0;
        endcase
    end

    assign mode = mode_q;

endmodule

// File: rtl/fs_irq.sv
module fs_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic ctl_wr,
    input  logic inh_sel,
    input  logic clr,
    output logic flag
);
    logic inhibit_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inhibit_q <= 1'b0;
        end else if (ctl_wr) begin
            inhibit_q <= inh_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_req && !inhibit_q) begin
            flag_q <= 1'b1;
        end else if (clr || (ctl_wr && inh_sel)) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import fs_pkg::*;
#(
    parameter int PERIOD   = 7456,
    parameter int WR_DELAY = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_en,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_data,
    input  logic       irq_clr,
    output logic       qtr_stb,
    output logic       half_stb,
    output logic       irq_flag
);
    logic       tick;
    fs_mode_e   mode;
    fs_action_t action;
    logic       five_sel;
    logic       inh_sel;
    logic       qtr_q, half_q;

    assign five_sel = ctl_data[CTL_FIVE_BIT];
    assign inh_sel  = ctl_data[CTL_INH_BIT];

    fs_divider #(
        .PERIOD   (PERIOD),
        .WR_DELAY (WR_DELAY)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .load_long (ctl_wr),
        .expire    (tick)
    );

    fs_step_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctl_wr   (ctl_wr),
        .five_sel (five_sel),
        .mode     (mode),
        .action   (action)
    );

    fs_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (tick && action.irq_set),
        .ctl_wr  (ctl_wr),
        .inh_sel (inh_sel),
        .clr     (irq_clr),
        .flag    (irq_flag)
    );

    // Strobe outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qtr_q  <= 1'b0;
            half_q <= 1'b0;
        end else if (ctl_wr) begin
            qtr_q  <= five_sel;
            half_q <= five_sel;
        end else begin
            qtr_q  <= tick && action.qtr;
            half_q <= tick && action.half;
        end
    end

    assign qtr_stb  = qtr_q;
    assign half_stb = half_q;

endmodule

// File: rtl/fs_checker.sv
module fs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_en,
    input logic       ctl_wr,
    input logic [7:0] ctl_data,
    input logic       irq_clr,
    input logic       qtr_stb,
    input logic       half_stb,
    input logic       irq_flag
);
    assert_half_has_qtr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        half_stb |-> qtr_stb);

    assert_strobe_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        qtr_stb |-> ($past(ctl_wr) || $past(cyc_en)));

    assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> (qtr_stb && half_stb && !$past(ctl_wr)));

    assert_wr_five_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_data[7]) |=> (qtr_stb && half_stb));

    assert_wr_four_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_data[7]) |=> (!qtr_stb && !half_stb));

    assert_inh_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_data[6]) |=> !irq_flag);

    assert_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (!irq_flag || half_stb));

endmodule

bind frame_sequencer fs_checker i_fs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .ctl_wr   (ctl_wr),
    .ctl_data (ctl_data),
    .irq_clr  (irq_clr),
    .qtr_stb  (qtr_stb),
    .half_stb (half_stb),
    .irq_flag (irq_flag)
);

// File: tb/test_frame_sequencer.sv
module test_frame_sequencer;
    localparam int P  = 12;
    localparam int WD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = 8'h00;
    logic       irq_clr = 1'b0;
    logic       qtr_stb, half_stb, irq_flag;

    frame_sequencer #(.PERIOD(P), .WR_DELAY(WD)) i_frame_sequencer (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ctl_wr(ctl_wr),
        .ctl_data(ctl_data), .irq_clr(irq_clr),
        .qtr_stb(qtr_stb), .half_stb(half_stb), .irq_flag(irq_flag)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    due;
        bit    q;
        bit    h;
        bit    f;
        string req;
    } exp_t;
    exp_t sb[$];

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    int m_div = P;
    int m_step = 0;
    bit m_five = 0, m_inh = 0, m_flag = 0, prev_stb = 0;

    task automatic check(string req, string what, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0b expected=%0b (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected outputs
    task automatic drive(bit en, bit wr, logic [7:0] d, bit clr);
        bit q = 0, h = 0, set = 0;
        string req = "R2";
        exp_t e;
        @(negedge clk);
        cyc_en = en; ctl_wr = wr; ctl_data = d; irq_clr = clr;
        if (wr) begin
            m_five = d[7]; m_inh = d[6]; m_step = 0; m_div = P + WD;
            q = d[7]; h = d[7];
            req = d[7] ? "R7" : "R6";
        end else if (en) begin
            if (m_div == 0) begin
                m_div = P;
                if (!m_five) begin
                    q = 1;
                    h = (m_step == 1 || m_step == 3);
                    set = (m_step == 3) && !m_inh;
                    m_step = (m_step + 1) % 4;
                    req = set ? "R4" : "R3";
                end else begin
                    q = (m_step != 3);
                    h = (m_step == 1 || m_step == 4);
                    m_step = (m_step + 1) % 5;
                    req = "R5";
                end
            end else begin
                m_div--;
            end
        end
        if (set) begin
            m_flag = 1;
            if (clr) req = "R9";
        end else if (clr) begin
            m_flag = 0; req = "R9";
        end else if (wr && d[6]) begin
            m_flag = 0; req = "R8";
        end
        if (!q && !h && prev_stb && req == "R2") req = "R10";
        prev_stb = q | h;
        e.due = cyc + 1; e.q = q; e.h = h; e.f = m_flag; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: pop and compare items that are due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, "qtr_stb", qtr_stb, e.q);
            check(e.req, "half_stb", half_stb, e.h);
            check(e.req, "irq_flag", irq_flag, e.f);
        end
    end

    task automatic run(int n, bit en, bit clr);
        for (int i = 0; i < n; i++) drive(en, 1'b0, 8'h00, clr);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check("R1", "qtr_stb", qtr_stb, 1'b0);
            check("R1", "half_stb", half_stb, 1'b0);
            check("R1", "irq_flag", irq_flag, 1'b0);
        end
        rst_n = 1'b1;
        // R1/R3/R4: first step timing and a full four-step run with interrupt
        run(110, 1, 0);
        // R9: clear the flag
        drive(1, 0, 8'h00, 1);
        run(5, 1, 0);
        // R2: gated enable
        for (int i = 0; i < 60; i++) drive(i % 3 == 0, 0, 8'h00, 0);
        // R8: inhibit write clears the flag, no interrupt afterwards
        run(60, 1, 0);
        drive(1, 1, 8'h40, 0);
        run(120, 1, 0);
        // R5/R7: five-step mode via write without enable
        drive(0, 1, 8'h80, 0);
        run(150, 1, 0);
        // R6: four-step write with enable high, no strobes
        drive(1, 1, 8'h00, 0);
        run(70, 1, 0);
        // R9: clear held while a set occurs; set wins
        run(80, 1, 1);
        run(20, 1, 0);
        // R6: write landing on a divider expiry; five-step with inhibit
        drive(1, 1, 8'hC0, 0);
        run(90, 1, 0);
        drive(1, 1, 8'h00, 0);
        run(30, 1, 0);
        run(3, 0, 0);
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        finish_up();
    end

    initial begin
        #500us;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_up();
        end
    end

endmodule